// File: doc/BRIEF.md
# Proxied External Bus Access Controller

This controller lets a bus master outside the chip read from or write to peripherals that sit behind the chip's external bus. The master raises an active-low request. The controller first gives up its own drive of the shared strobe, read/write, address and data lines and turns the external data buffer toward the write direction. It then grants the bus, and it enables the buffer in the same cycle.

The master presents one address phase: strobe low, with read/write and address valid. The controller latches that phase and withdraws the grant. During a turnaround cycle it also gives up its drive of the ready line. It then replays the access to the resource on its own outputs: it asserts strobe, drives the latched read/write and address, and pulls low the chip select that the upper address bits decode to. It holds the access until the resource signals ready. It then disables the buffer, turns the buffer back to the read direction, drives ready and the other shared lines to their inactive levels, and becomes idle.

Every shared line has an output value and a separate output-enable, so the tri-state pads sit outside this block. Upper address bits that decode to no chip select end the access after the turnaround cycle, and no chip select is asserted.

Top module: `xbus_proxy`

## Requirements
- R1: While reset is high, and in idle, the outputs are: grant high; buffer enable high; buffer direction high; all chip selects high; strobe out high; read/write out high; address out zero; ready out high. The strobe, read/write, address, data and ready output-enables are all 1.
- R2: If request is low and ready-in is high in idle, the next cycle has these outputs: strobe, read/write, address and data output-enables at 0; direction low; grant and buffer enable still high. One cycle later, grant and buffer enable go low together.
- R3: A granted cycle in which strobe-in and request are both sampled low latches the upper address, lower address and read/write. In the next cycle grant is high, buffer enable stays low, the ready output-enable is 0, and strobe, read/write and address are still not driven.
- R4: If request is sampled high while grant is low and strobe-in has not been seen, the next cycle returns to the idle outputs of R1 and no chip select is asserted.
- R5: An upper-address value k with 1 <= k <= CS_N selects chip select k-1. With defaults, 01 selects cs_n[0] and 10 selects cs_n[1]; 00 and 11 select none.
- R6: The cycle after the turnaround, a mapped access drives the following, all with output-enables at 1: the selected chip select low, strobe out low, and the latched read/write and address. These stay stable while ready-in is sampled high.
- R7: The first cycle in which ready-in is sampled low during the replayed access is followed by the idle outputs of R1. With no ready-in, the access is held for any number of cycles.
- R8: An unmapped access goes from the turnaround cycle straight to the idle outputs of R1, and no chip select is ever asserted.
- R9: In idle, a request is ignored for as long as ready-in is sampled low. The outputs stay as in R1.
- R10: At most one chip select is low at a time, and grant is never low while a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Master bus request, active low |
| gnt_n | output | 1 | Bus grant to master, active low |
| strb_n_i | input | 1 | Address strobe from master, active low |
| strb_n_o | output | 1 | Address strobe driven to resource, active low |
| strb_oe | output | 1 | Output-enable of strobe |
| rw_i | input | 1 | Read/write from master, 1 read, 0 write |
| rw_o | output | 1 | Read/write driven to resource |
| rw_oe | output | 1 | Output-enable of read/write |
| adr_hi_i | input | HI_W | Upper address bits from master |
| adr_lo_i | input | LO_W | Word address bits from master |
| adr_hi_o | output | HI_W | Upper address bits driven to resource |
| adr_lo_o | output | LO_W | Word address bits driven to resource |
| adr_oe | output | 1 | Output-enable of both address groups |
| dat_oe | output | 1 | Output-enable of the data bus |
| rdy_n_i | input | 1 | Ready from resource, active low |
| rdy_n_o | output | 1 | Ready driven by controller (inactive level) |
| rdy_oe | output | 1 | Output-enable of ready |
| cs_n | output | CS_N | Chip selects, active low |
| buf_en_n | output | 1 | External data buffer enable, active low |
| buf_dir | output | 1 | Buffer direction, 1 read, 0 write |

## Verification
The assertions check the following on every cycle:
- The chip selects are mutually exclusive, and none is low while the grant is low.
- Whenever the grant is out, the shared lines are released and the buffer faces the write direction.
- Grant and buffer enable fall together.
- The grant is withdrawn after the latched address phase, and also when the request is withdrawn.
- The chip select agrees with the driven upper address, and the replayed access is stable until ready.
- The ready edge leads to the idle outputs.
- A low ready blocks a new request.

Some behaviour can only be shown by the bench's scenarios: the exact cycle sequence, the values latched from the master, the unmapped decode that produces no select, a long ready delay, and recovery after an aborted request.

// File: rtl/xbus_proxy_pkg.sv
package xbus_proxy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REL   = 3'd1,
    ST_GNT   = 3'd2,
    ST_TURN  = 3'd3,
    ST_PROXY = 3'd4
  } xbp_state_e;

  typedef struct packed {
    logic gnt_n;
    logic buf_en_n;
    logic buf_dir;
    logic bus_oe;
    logic dat_oe;
    logic rdy_oe;
    logic drive_access;
  } xbp_ctl_t;

  function automatic xbp_ctl_t ctl_of(xbp_state_e s);
    xbp_ctl_t c;
    c.gnt_n        = (s != ST_GNT);
    c.buf_en_n     = !(s == ST_GNT || s == ST_TURN || s == ST_PROXY);
    c.buf_dir      = (s == ST_IDLE);
    c.bus_oe       = (s == ST_IDLE || s == ST_PROXY);
    c.dat_oe       = (s == ST_IDLE);
    c.rdy_oe       = (s == ST_IDLE || s == ST_REL || s == ST_GNT);
    c.drive_access = (s == ST_PROXY);
    return c;
  endfunction
endpackage

// File: rtl/xbus_proxy_fsm.sv
module xbus_proxy_fsm
  import xbus_proxy_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_n,
  input  logic       strb_n_i,
  input  logic       rdy_n_i,
  input  logic       mapped,
  output xbp_state_e st_d,
  output logic       cap_en
);
  xbp_state_e st_q;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (!req_n && rdy_n_i) st_d = ST_REL;
      ST_REL:   st_d = ST_GNT;
      ST_GNT: begin
        if (!req_n && !strb_n_i) begin
          cap_en = 1'b1;
          st_d   = ST_TURN;
        end else if (req_n) begin
          st_d = ST_IDLE;
        end
      end
      ST_TURN:  st_d = mapped ? ST_PROXY : ST_IDLE;
      ST_PROXY: if (!rdy_n_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/xbus_proxy_latch.sv
module xbus_proxy_latch #(
  parameter int HI_W = 2,
  parameter int LO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic [HI_W-1:0] hi_i,
  input  logic [LO_W-1:0] lo_i,
  input  logic            rw_i,
  output logic [HI_W-1:0] hi_q,
  output logic [LO_W-1:0] lo_q,
  output logic            rw_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
      rw_q <= 1'b1;
    end else if (cap_en) begin
      hi_q <= hi_i;
      lo_q <= lo_i;
      rw_q <= rw_i;
    end
  end
endmodule

// File: rtl/xbus_proxy_csdec.sv
module xbus_proxy_csdec #(
  parameter int HI_W = 2,
  parameter int CS_N = 2
) (
  input  logic [HI_W-1:0] hi,
  output logic [CS_N-1:0] sel,
  output logic            mapped
);
  for (genvar k = 0; k < CS_N; k++) begin : g_sel
    assign sel[k] = (hi == HI_W'(k + 1));
  end
  assign mapped = |sel;
endmodule

// File: rtl/xbus_proxy.sv
module xbus_proxy
  import xbus_proxy_pkg::*;
#(
  parameter int HI_W = 2,
  parameter int LO_W = 16,
  parameter int CS_N = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_n,
  output logic            gnt_n,
  input  logic            strb_n_i,
  output logic            strb_n_o,
  output logic            strb_oe,
  input  logic            rw_i,
  output logic            rw_o,
  output logic            rw_oe,
  input  logic [HI_W-1:0] adr_hi_i,
  input  logic [LO_W-1:0] adr_lo_i,
  output logic [HI_W-1:0] adr_hi_o,
  output logic [LO_W-1:0] adr_lo_o,
  output logic            adr_oe,
  output logic            dat_oe,
  input  logic            rdy_n_i,
  output logic            rdy_n_o,
  output logic            rdy_oe,
  output logic [CS_N-1:0] cs_n,
  output logic            buf_en_n,
  output logic            buf_dir
);
  xbp_state_e      st_d;
  logic            cap_en;
  logic            mapped;
  logic [CS_N-1:0] sel;
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;
  logic            rw_q;
  xbp_ctl_t        ctl;

  xbus_proxy_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_n    (req_n),
    .strb_n_i (strb_n_i),
    .rdy_n_i  (rdy_n_i),
    .mapped   (mapped),
    .st_d     (st_d),
    .cap_en   (cap_en)
  );

  xbus_proxy_latch #(.HI_W(HI_W), .LO_W(LO_W)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .cap_en (cap_en),
    .hi_i   (adr_hi_i),
    .lo_i   (adr_lo_i),
    .rw_i   (rw_i),
    .hi_q   (hi_q),
    .lo_q   (lo_q),
    .rw_q   (rw_q)
  );

  xbus_proxy_csdec #(.HI_W(HI_W), .CS_N(CS_N)) u_dec (
    .hi     (hi_q),
    .sel    (sel),
    .mapped (mapped)
  );

  assign ctl = ctl_of(st_d);

  // Outputs registered from the next state so that pins change with the state.
  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_n    <= 1'b1;
      buf_en_n <= 1'b1;
      buf_dir  <= 1'b1;
      strb_oe  <= 1'b1;
      rw_oe    <= 1'b1;
      adr_oe   <= 1'b1;
      dat_oe   <= 1'b1;
      rdy_oe   <= 1'b1;
      rdy_n_o  <= 1'b1;
      strb_n_o <= 1'b1;
      rw_o     <= 1'b1;
      adr_hi_o <= '0;
      adr_lo_o <= '0;
      cs_n     <= '1;
    end else begin
      gnt_n    <= ctl.gnt_n;
      buf_en_n <= ctl.buf_en_n;
      buf_dir  <= ctl.buf_dir;
      strb_oe  <= ctl.bus_oe;
      rw_oe    <= ctl.bus_oe;
      adr_oe   <= ctl.bus_oe;
      dat_oe   <= ctl.dat_oe;
      rdy_oe   <= ctl.rdy_oe;
      rdy_n_o  <= 1'b1;
      strb_n_o <= !ctl.drive_access;
      rw_o     <= ctl.drive_access ? rw_q : 1'b1;
      adr_hi_o <= ctl.drive_access ? hi_q : '0;
      adr_lo_o <= ctl.drive_access ? lo_q : '0;
      cs_n     <= ctl.drive_access ? ~sel : '1;
    end
  end
endmodule

// File: rtl/xbus_proxy_chk.sv
module xbus_proxy_chk #(
  parameter int HI_W = 2,
  parameter int LO_W = 16,
  parameter int CS_N = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            req_n,
  input logic            gnt_n,
  input logic            strb_n_i,
  input logic            strb_n_o,
  input logic            strb_oe,
  input logic            rw_i,
  input logic            rw_o,
  input logic            rw_oe,
  input logic [HI_W-1:0] adr_hi_i,
  input logic [LO_W-1:0] adr_lo_i,
  input logic [HI_W-1:0] adr_hi_o,
  input logic [LO_W-1:0] adr_lo_o,
  input logic            adr_oe,
  input logic            dat_oe,
  input logic            rdy_n_i,
  input logic            rdy_n_o,
  input logic            rdy_oe,
  input logic [CS_N-1:0] cs_n,
  input logic            buf_en_n,
  input logic            buf_dir
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (gnt_n && buf_en_n && buf_dir && (cs_n == '1) && strb_oe && rdy_oe && rdy_n_o));

  a_r10_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  a_r10_gnt_vs_cs: assert property (@(posedge clk) disable iff (rst)
    !gnt_n |-> (cs_n == '1));

  a_r2_released_when_granted: assert property (@(posedge clk) disable iff (rst)
    !gnt_n |-> (!strb_oe && !rw_oe && !adr_oe && !dat_oe && !buf_dir));

  a_r2_enable_with_grant: assert property (@(posedge clk) disable iff (rst)
    $fell(gnt_n) |-> $fell(buf_en_n));

  a_r3_grant_withdrawn: assert property (@(posedge clk) disable iff (rst)
    (!gnt_n && !strb_n_i && !req_n) |=> (gnt_n && !buf_en_n && !rdy_oe && !strb_oe));

  a_r4_abort: assert property (@(posedge clk) disable iff (rst)
    (!gnt_n && req_n) |=> (gnt_n && buf_en_n && buf_dir && (cs_n == '1)));

  a_r5_cs_matches_addr: assert property (@(posedge clk) disable iff (rst)
    (cs_n != '1) |-> ((adr_hi_o != '0) && (int'(adr_hi_o) <= CS_N) &&
                      !cs_n[adr_hi_o - 1'b1]));

  a_r6_hold_access: assert property (@(posedge clk) disable iff (rst)
    ((cs_n != '1) && rdy_n_i) |=> ($stable(cs_n) && $stable(adr_hi_o) &&
                                   $stable(adr_lo_o) && $stable(rw_o) && !strb_n_o && strb_oe));

  a_r7_ready_ends: assert property (@(posedge clk) disable iff (rst)
    ((cs_n != '1) && !rdy_n_i) |=> ((cs_n == '1) && buf_en_n && buf_dir && rdy_oe && rdy_n_o));

  a_r9_ready_blocks: assert property (@(posedge clk) disable iff (rst)
    (buf_dir && !rdy_n_i) |=> buf_dir);
endmodule

bind xbus_proxy xbus_proxy_chk #(.HI_W(HI_W), .LO_W(LO_W), .CS_N(CS_N)) u_chk (.*);

// File: tb/sim_xbus_proxy.sv
module sim_xbus_proxy;
  localparam int CLK_PERIOD = 10;
  localparam int HI_W = 2;
  localparam int LO_W = 16;
  localparam int CS_N = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_n = 1'b1, strb_n_i = 1'b1, rw_i = 1'b1, rdy_n_i = 1'b1;
  logic [HI_W-1:0] adr_hi_i = '0;
  logic [LO_W-1:0] adr_lo_i = '0;
  logic gnt_n, strb_n_o, strb_oe, rw_o, rw_oe, adr_oe, dat_oe, rdy_n_o, rdy_oe;
  logic buf_en_n, buf_dir;
  logic [HI_W-1:0] adr_hi_o;
  logic [LO_W-1:0] adr_lo_o;
  logic [CS_N-1:0] cs_n;

  int checks = 0, errors = 0, edges = 0, rdy_dly = 0, rcnt = 0;
  bit hold_rdy = 0, done = 0;

  // reference model state: 0 idle, 1 release, 2 granted, 3 turnaround, 4 replay
  int ph = 0;
  logic [HI_W-1:0] m_hi = '0;
  logic [LO_W-1:0] m_lo = '0;
  logic m_rw = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_proxy #(.HI_W(HI_W), .LO_W(LO_W), .CS_N(CS_N)) u0 (
    .clk(clk), .rst(rst), .req_n(req_n), .gnt_n(gnt_n),
    .strb_n_i(strb_n_i), .strb_n_o(strb_n_o), .strb_oe(strb_oe),
    .rw_i(rw_i), .rw_o(rw_o), .rw_oe(rw_oe),
    .adr_hi_i(adr_hi_i), .adr_lo_i(adr_lo_i), .adr_hi_o(adr_hi_o), .adr_lo_o(adr_lo_o),
    .adr_oe(adr_oe), .dat_oe(dat_oe), .rdy_n_i(rdy_n_i), .rdy_n_o(rdy_n_o), .rdy_oe(rdy_oe),
    .cs_n(cs_n), .buf_en_n(buf_en_n), .buf_dir(buf_dir)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    edges++;
    if (rst) ph = 0;
    else begin
      case (ph)
        0: if (!req_n && rdy_n_i) ph = 1;
        1: ph = 2;
        2: if (!req_n && !strb_n_i) begin
             m_hi = adr_hi_i; m_lo = adr_lo_i; m_rw = rw_i; ph = 3;
           end else if (req_n) ph = 0;
        3: ph = (m_hi >= 1 && int'(m_hi) <= CS_N) ? 4 : 0;
        4: if (!rdy_n_i) ph = 0;
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (edges > 0 && !done) begin
      logic [CS_N-1:0] ecs;
      ecs = '1;
      if (ph == 4) ecs[m_hi - 1] = 1'b0;
      chk("R2/R3 gnt_n",    gnt_n,    ph != 2);
      chk("R2/R7 buf_en_n", buf_en_n, !(ph >= 2));
      chk("R1/R2 buf_dir",  buf_dir,  ph == 0);
      chk("R2/R6 strb_oe",  strb_oe,  ph == 0 || ph == 4);
      chk("R2/R6 rw_oe",    rw_oe,    ph == 0 || ph == 4);
      chk("R2/R6 adr_oe",   adr_oe,   ph == 0 || ph == 4);
      chk("R1/R2 dat_oe",   dat_oe,   ph == 0);
      chk("R3/R7 rdy_oe",   rdy_oe,   ph <= 2);
      chk("R1 rdy_n_o",     rdy_n_o,  1);
      chk("R6 strb_n_o",    strb_n_o, ph != 4);
      chk("R6 rw_o",        rw_o,     (ph == 4) ? m_rw : 1'b1);
      chk("R6 adr_hi_o",    adr_hi_o, (ph == 4) ? m_hi : '0);
      chk("R6 adr_lo_o",    adr_lo_o, (ph == 4) ? m_lo : '0);
      chk("R5/R8/R10 cs_n", cs_n,     ecs);
    end
  end

  // resource model: ready after rdy_dly cycles of an active select
  always @(negedge clk) begin
    if (cs_n !== '1) begin
      rdy_n_i = !(hold_rdy || rcnt >= rdy_dly);
      rcnt++;
    end else begin
      rcnt = 0;
      rdy_n_i = !hold_rdy;
    end
  end

  task automatic access(input logic [HI_W-1:0] hi, input logic [LO_W-1:0] lo,
                        input logic rw, input int pre, input int sdly,
                        input int rdly, input bit abort);
    rdy_dly = rdly;
    @(negedge clk);
    hold_rdy = (pre > 0);
    req_n = 1'b0;
    for (int i = 0; i < pre; i++) @(negedge clk);
    hold_rdy = 0;
    while (gnt_n) @(negedge clk);
    if (abort) begin
      req_n = 1'b1;
    end else begin
      for (int i = 0; i < sdly; i++) @(negedge clk);
      strb_n_i = 1'b0; adr_hi_i = hi; adr_lo_i = lo; rw_i = rw;
      @(negedge clk);
      strb_n_i = 1'b1; req_n = 1'b1; adr_hi_i = '0; adr_lo_i = '0; rw_i = 1'b1;
    end
    for (int i = 0; i < rdly + 8; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    access(2'b01, 16'h1234, 1'b1, 0, 0, 0, 0);   // R5 cs0, R6 read, R7 fast ready
    access(2'b10, 16'hBEEF, 1'b0, 0, 2, 3, 0);   // R5 cs1, R6 write, strobe delayed
    access(2'b00, 16'h0F0F, 1'b1, 0, 0, 0, 0);   // R8 unmapped low
    access(2'b11, 16'hFFFF, 1'b1, 0, 1, 0, 0);   // R8 unmapped high
    access(2'b01, 16'h5555, 1'b1, 0, 0, 0, 1);   // R4 abort before strobe
    access(2'b10, 16'hA5A5, 1'b1, 4, 0, 1, 0);   // R9 ready low blocks request
    access(2'b01, 16'h0001, 1'b0, 0, 0, 40, 0);  // R7 long hold
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule